// File: doc/BRIEF.md
# PWM Drive Gate with Latched Overcurrent Protection

This block decides, every clock cycle, whether the commutation stage of a motor controller may drive its power switches. An internal digital sawtooth, an up-counter slowed by a programmable prescaler, is compared with a speed threshold word. Drive is allowed while the threshold is below the ramp value. The duty cycle therefore falls as the threshold rises. An external enable input also gates the drive. With the ramp bypassed, the enable can serve as the chopped PWM signal by itself.

An overcurrent indication blocks the drive in the same cycle it is seen and sets a fault latch. The latch keeps the drive blocked after the indication goes away. It clears only on the next chopping event: a synchronized rising edge of the enable, or the restart of the sawtooth when its count wraps to zero. It clears only if overcurrent is absent at that moment. As a result, fault retries happen at most once per PWM period. A brake request overrides all of this and forces the drive-allow high, so that the commutation stage can apply its braking pattern.

Top module: `pwm_drive_gate`

## Requirements
- R1: With brake low, synchronized enable high, no overcurrent, latch clear and ramp not bypassed, drive_ok is 1 when thresh < ramp count and 0 when thresh >= ramp count.
- R2: With brake low, oc_in high forces drive_ok to 0 in the same cycle, without waiting for a clock edge.
- R3: oc_in high at a clock edge sets the fault latch. While the latch is set and brake is low, drive_ok stays 0 until a clearing event occurs.
- R4: A rising edge of en_in clears the latch if oc_in is low at that edge. The edge is seen after a 2-flop synchronizer, and the clearing edge is the third clock edge after the change. drive_ok may then be 1 again.
- R5: With the ramp running and en_in held high, the latch clears at the clock edge where the ramp count wraps from 255 to 0, if oc_in is low at that edge.
- R6: If oc_in is high at a clearing event, the latch stays set.
- R7: brake_in high forces drive_ok to 1, whatever the enable, ramp, latch and oc_in values are. The latch still records overcurrent during brake.
- R8: With brake low, a synchronized en_in of 0 forces drive_ok to 0, whatever the ramp value is. In reset the synchronized enable is 0, so drive_ok is 0.
- R9: With ramp_bypass high, the ramp count is held at 0 and produces no restart events. drive_ok then depends only on enable and the latch, so only an enable edge can clear the latch.
- R10: The ramp count is 8 bits wide and wraps from 255 to 0. It advances once every prescale+1 clock cycles, so with thresh = 0 drive_ok is 1 for 255 of every 256 ramp steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_in | input | 1 | External enable, asynchronous; chopped PWM input when the ramp is bypassed |
| oc_in | input | 1 | Overcurrent indication, synchronous to clk, active high |
| brake_in | input | 1 | Brake request, active high, highest priority |
| ramp_bypass | input | 1 | 1 holds the ramp at 0 and removes it from gating |
| prescale | input | 8 | Ramp step period minus one, in clock cycles |
| thresh | input | 8 | Speed threshold compared against the ramp count |
| drive_ok | output | 1 | Drive allow for the commutation outputs |

## Verification
The assertions assume that oc_in and brake_in are synchronous to clk. They also assume that prescale and ramp_bypass change only between test phases, while the bench lets the ramp settle again. The stimulus changes every input on the falling clock edge. It keeps ramp_bypass steady over each measurement window. It checks the ramp duty cycle by counting high cycles over whole ramp periods, so the result does not depend on the ramp phase. The bench asserts the only asynchronous input, en_in, for several cycles at a time, so that each edge passes cleanly through the synchronizer.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

    typedef enum logic [1:0] {
        GATE_OFF   = 2'd0,
        GATE_FAULT = 2'd1,
        GATE_RUN   = 2'd2,
        GATE_BRAKE = 2'd3
    } gate_mode_e;

    function automatic gate_mode_e pick_mode(
        input logic brake,
        input logic fault,
        input logic en_ok,
        input logic ramp_ok
    );
        gate_mode_e m;
        if (brake)
            m = GATE_BRAKE;
        else if (fault)
            m = GATE_FAULT;
        else if (en_ok && ramp_ok)
            m = GATE_RUN;
        else
            m = GATE_OFF;
        return m;
    endfunction

    function automatic logic mode_drives(input gate_mode_e m);
        return (m == GATE_BRAKE) || (m == GATE_RUN);
    endfunction

endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [PRE_W-1:0] prescale,
    output logic [CNT_W-1:0] count,
    output logic             restart
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } ramp_st_t;

    ramp_st_t st_q, st_d;
    logic     restart_d;

    always_comb begin
        st_d      = st_q;
        restart_d = 1'b0;
        if (hold) begin
            st_d.pre = '0;
            st_d.cnt = '0;
        end else if (st_q.pre >= prescale) begin
            st_d.pre  = '0;
            st_d.cnt  = st_q.cnt + 1'b1;
            restart_d = (st_q.cnt == CNT_TOP);
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign restart = restart_d;

endmodule

// File: rtl/pwm_en_sync.sv
module pwm_en_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_async,
    output logic en_sync,
    output logic en_rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], en_async};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en_sync = st_q.sh[STAGES-1];
    assign en_rise = st_q.sh[STAGES-1] & ~st_q.prev;

endmodule

// File: rtl/pwm_oc_latch.sv
module pwm_oc_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic oc,
    input  logic clear_evt,
    output logic latched,
    output logic block
);
    typedef struct packed {
        logic set;
    } oc_st_t;

    oc_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (oc)
            st_d.set = 1'b1;
        else if (clear_evt)
            st_d.set = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign latched = st_q.set;
    assign block   = oc | st_q.set;

endmodule

// File: rtl/pwm_drive_gate.sv
module pwm_drive_gate #(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned PRE_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic             oc_in,
    input  logic             brake_in,
    input  logic             ramp_bypass,
    input  logic [PRE_W-1:0] prescale,
    input  logic [CNT_W-1:0] thresh,
    output logic             drive_ok
);
    import pwm_gate_pkg::*;

    logic [CNT_W-1:0] cnt_s;
    logic             wrap_s;
    logic             en_sync_s;
    logic             en_rise_s;
    logic             latch_s;
    logic             block_s;
    logic             ramp_ok_s;
    logic             clear_s;
    gate_mode_e       mode_s;

    pwm_ramp #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (ramp_bypass),
        .prescale (prescale),
        .count    (cnt_s),
        .restart  (wrap_s)
    );

    pwm_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_async (en_in),
        .en_sync  (en_sync_s),
        .en_rise  (en_rise_s)
    );

    assign clear_s = en_rise_s | wrap_s;

    pwm_oc_latch u_oc (
        .clk       (clk),
        .rst_n     (rst_n),
        .oc        (oc_in),
        .clear_evt (clear_s),
        .latched   (latch_s),
        .block     (block_s)
    );

    always_comb begin
        ramp_ok_s = ramp_bypass | (thresh < cnt_s);
        mode_s    = pick_mode(brake_in, block_s, en_sync_s, ramp_ok_s);
        drive_ok  = mode_drives(mode_s);
    end

endmodule

// File: rtl/pwm_drive_gate_chk.sv
module pwm_drive_gate_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oc_in,
    input logic             brake_in,
    input logic             ramp_bypass,
    input logic [CNT_W-1:0] thresh,
    input logic [CNT_W-1:0] cnt,
    input logic             wrap,
    input logic             en_sync,
    input logic             en_rise,
    input logic             latch,
    input logic             drive_ok
);
    a_r1_ramp_block: assert property (@(posedge clk) disable iff (!rst_n)
        (!brake_in && !ramp_bypass && (thresh >= cnt)) |-> !drive_ok);

    a_r2_oc_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_in && !brake_in) |-> !drive_ok);

    a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && !en_rise && !wrap) |=> latch);

    a_r3_latch_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && !brake_in) |-> !drive_ok);

    a_r4_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise && !oc_in) |=> !latch);

    a_r5_wrap_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !oc_in) |=> !latch);

    a_r6_oc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        oc_in |=> latch);

    a_r7_brake_wins: assert property (@(posedge clk) disable iff (!rst_n)
        brake_in |-> drive_ok);

    a_r8_enable_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_sync && !brake_in) |-> !drive_ok);

    a_r9_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_bypass |-> !wrap);

    a_r9_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_bypass |=> (cnt == '0));

    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ramp_bypass && $past(!ramp_bypass)) |->
            ((cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1))));

endmodule

bind pwm_drive_gate pwm_drive_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .oc_in       (oc_in),
    .brake_in    (brake_in),
    .ramp_bypass (ramp_bypass),
    .thresh      (thresh),
    .cnt         (cnt_s),
    .wrap        (wrap_s),
    .en_sync     (en_sync_s),
    .en_rise     (en_rise_s),
    .latch       (latch_s),
    .drive_ok    (drive_ok)
);

// File: tb/pwm_drive_gate_test.sv
`timescale 1ns/1ps
module pwm_drive_gate_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_in = 1'b1;
    logic       oc_in = 1'b0;
    logic       brake_in = 1'b0;
    logic       ramp_bypass = 1'b1;
    logic [7:0] prescale = 8'd0;
    logic [7:0] thresh = 8'd0;
    logic       drive_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_drive_gate uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_in       (en_in),
        .oc_in       (oc_in),
        .brake_in    (brake_in),
        .ramp_bypass (ramp_bypass),
        .prescale    (prescale),
        .thresh      (thresh),
        .drive_ok    (drive_ok)
    );

    // vector bits: {brake, oc, en, expected drive_ok}; ramp bypassed throughout
    localparam int NVEC = 13;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b0011, // R8 enable high, clean
        4'b0110, // R2 fault blocks
        4'b0010, // R3 latch holds after fault drops
        4'b0000, // R8 enable low
        4'b0011, // R4 enable edge clears
        4'b1111, // R7 brake overrides fault
        4'b0010, // R7 latch recorded during brake
        4'b1001, // R7 brake overrides enable low
        4'b0000, // R8 enable low
        4'b0110, // R6 edge while fault present
        4'b0010, // R6 latch still set
        4'b0000, // R8 enable low
        4'b0011  // R4 edge clears
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s drive_ok actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_high(input int n, output int ones);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (drive_ok === 1'b1) ones++;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int ones;
        int lowrun;
        bit recovered;
        repeat (3) @(negedge clk);
        check("R8 reset", drive_ok, 1'b0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            brake_in = VEC[v][3];
            oc_in    = VEC[v][2];
            en_in    = VEC[v][1];
            cycles(4);
            check($sformatf("R3/R4/R6/R7/R8 vector %0d", v), drive_ok, VEC[v][0]);
        end

        // R2: same-cycle block, no clock edge in between
        oc_in = 1'b1;
        #1;
        check("R2 immediate", drive_ok, 1'b0);
        @(negedge clk);
        oc_in = 1'b0;
        en_in = 1'b0;
        cycles(4);
        en_in = 1'b1;
        cycles(4);

        // R9: bypass, threshold at max has no effect
        thresh = 8'hFF;
        cycles(2);
        check("R9 bypass ignores thresh", drive_ok, 1'b1);

        // R1 / R10 duty over whole ramp periods
        ramp_bypass = 1'b0;
        prescale = 8'd0;
        thresh = 8'd0;
        cycles(300);
        count_high(256, ones);
        check_int("R10 thresh0 duty", ones, 255);
        thresh = 8'd100;
        cycles(2);
        count_high(256, ones);
        check_int("R1 thresh100 duty", ones, 155);
        thresh = 8'hFF;
        cycles(2);
        count_high(256, ones);
        check_int("R1 thresh255 duty", ones, 0);
        thresh = 8'd0;
        prescale = 8'd3;
        cycles(1100);
        count_high(1024, ones);
        check_int("R10 prescale3 duty", ones, 1020);
        prescale = 8'd0;
        cycles(300);

        // R8: enable low blocks the running ramp
        en_in = 1'b0;
        cycles(4);
        count_high(256, ones);
        check_int("R8 enable low duty", ones, 0);
        en_in = 1'b1;
        cycles(4);

        // R5: wrap clears the latch with enable held high
        @(negedge clk);
        oc_in = 1'b1;
        @(negedge clk);
        oc_in = 1'b0;
        recovered = 1'b0;
        lowrun = 0;
        for (int i = 0; i < 300 && !recovered; i++) begin
            @(negedge clk);
            if (drive_ok === 1'b1) recovered = 1'b1;
            else lowrun++;
        end
        check("R5 wrap recovery", recovered, 1'b1);
        check("R5 bounded hold", (lowrun >= 1 && lowrun <= 258), 1'b1);

        // R9: bypass, latch survives with no enable edge
        ramp_bypass = 1'b1;
        cycles(4);
        @(negedge clk);
        oc_in = 1'b1;
        @(negedge clk);
        oc_in = 1'b0;
        count_high(600, ones);
        check_int("R9 no wrap clear", ones, 0);
        en_in = 1'b0;
        cycles(4);
        en_in = 1'b1;
        cycles(4);
        check("R4 edge clears in bypass", drive_ok, 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule